// File: doc/BRIEF.md
# External Interrupt Edge/Level Latch

This block is the external interrupt front end of a small microcontroller core. It watches one dedicated interrupt pin, which is active low, and four general-purpose port pins, which are active high. The port pins take part only when a port-interrupt enable is set. One sensitivity bit selects the trigger mode for every source. In edge-only mode, only a transition into the active state counts. In edge-plus-level mode, a source held in its active state also keeps requesting.

Every pin passes through a two-stage synchronizer. The synchronized sources are then converted to active-high form and ORed into one combined active signal, which sets a single request latch. The latch drives a pending flag that software can read. That flag, gated by an interrupt enable and by the CPU's global mask bit, becomes the interrupt request to the CPU. The latch is cleared when the CPU fetches the interrupt vector or when software writes an acknowledge strobe. This lets an edge that arrives during the service routine raise a fresh pending request.

The synchronized level of the dedicated pin is also brought out on its own. Pin-test branch instructions use it.

Top module: `ext_irq_latch`

## Requirements
- R1: `pin_level` shows the dedicated pin as it was two rising clock edges earlier. This holds whatever the enable, mask and configuration inputs are.
- R2: When `cfg_level`=0, a high-to-low transition on `irq_n_pin` sets `pend_flag` at the third rising edge after the pin changes.
- R3: When `cfg_port_en`=1, a low-to-high transition on any bit of `port_pins` sets `pend_flag` with the same three-edge latency.
- R4: When `cfg_port_en`=0, `port_pins` have no effect on `pend_flag`.
- R5: When `cfg_level`=1, the latch is set on every cycle in which any enabled source is active. A clear strobe therefore cannot drop `pend_flag` while a source stays active.
- R6: When `cfg_level`=0, a source held in its active state does not set the latch again after the latch has been cleared.
- R7: A pulse on `vec_fetch` or on `ack_clr` clears `pend_flag` on the next edge. A new active edge that arrives later, during service, sets it again.
- R8: If a set condition and a clear strobe occur in the same cycle, the latch ends up set.
- R9: `cpu_req` equals `pend_flag & irq_en & ~cpu_mask`, combinationally. A pending request therefore appears on `cpu_req` in the same cycle that `cpu_mask` falls.
- R10: While `rst_n` is low, `pend_flag`=0, `cpu_req`=0 and `pin_level`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n_pin | input | 1 | Dedicated interrupt pin, active low |
| port_pins | input | PORT_W | Port interrupt pins, active high |
| cfg_port_en | input | 1 | Lets the port pins take part in interrupt generation |
| cfg_level | input | 1 | 0: edge only; 1: edge plus level |
| irq_en | input | 1 | Interrupt enable that gates the request |
| cpu_mask | input | 1 | CPU global interrupt mask (1 = masked) |
| ack_clr | input | 1 | Software acknowledge that clears the latch |
| vec_fetch | input | 1 | Vector-fetch strobe that clears the latch |
| cpu_req | output | 1 | Interrupt request to the CPU |
| pend_flag | output | 1 | Readable pending flag (latch state) |
| pin_level | output | 1 | Synchronized level of the dedicated pin |

## Verification
The hardest case to reach is a collision inside one cycle: the set condition has to arrive in the same cycle as a vector fetch or acknowledge. Only then does it show whether the set wins, or whether a re-armed edge is lost during service. The stimulus reaches it in two ways. Directed sequences count the three-edge latency and place the strobe exactly on the setting cycle, both in level mode and for a fresh edge. Random phases then pulse the clear strobes often while the pins toggle, so the same collisions recur under every mix of mode and enable.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              cfg_port_en,
  input  logic              cfg_level,
  input  logic              irq_en,
  input  logic              cpu_mask,
  input  logic              ack_clr,
  input  logic              vec_fetch,
  output logic              cpu_req,
  output logic              pend_flag,
  output logic              pin_level
);

  logic [1:0]        irq_sr;
  logic [PORT_W-1:0] port_s1, port_s2;
  logic              act_d, pend_q;
  logic              irq_sync, comb_act, set_evt, clr_evt;

  assign irq_sync = irq_sr[1];
  assign comb_act = ~irq_sync | (cfg_port_en & (|port_s2));
  assign set_evt  = (comb_act & ~act_d) | (cfg_level & comb_act);
  assign clr_evt  = ack_clr | vec_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sr  <= 2'b11;
      port_s1 <= '0;
      port_s2 <= '0;
      act_d   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      irq_sr  <= {irq_sr[0], irq_n_pin};
      port_s1 <= port_pins;
      port_s2 <= port_s1;
      act_d   <= comb_act;
      if (set_evt)      pend_q <= 1'b1;
      else if (clr_evt) pend_q <= 1'b0;
    end
  end

  assign pend_flag = pend_q;
  assign cpu_req   = pend_q & irq_en & ~cpu_mask;
  assign pin_level = irq_sync;

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (pend_flag && irq_en && !cpu_mask)); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !pend_flag); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend_flag); // R8
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && comb_act) |=> pend_flag); // R5
  AST_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_port_en && irq_sync && !pend_flag) |=> !pend_flag); // R4

endmodule

// File: tb/test_ext_irq_latch.sv
module test_ext_irq_latch;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_n_pin = 1'b1;
  logic [PW-1:0] port_pins = '0;
  logic cfg_port_en = 1'b0, cfg_level = 1'b0, irq_en = 1'b1, cpu_mask = 1'b0;
  logic ack_clr = 1'b0, vec_fetch = 1'b0;
  logic cpu_req, pend_flag, pin_level;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_latch #(.PORT_W(PW)) i_ext_irq_latch (
    .clk(clk), .rst_n(rst_n), .irq_n_pin(irq_n_pin), .port_pins(port_pins),
    .cfg_port_en(cfg_port_en), .cfg_level(cfg_level), .irq_en(irq_en),
    .cpu_mask(cpu_mask), .ack_clr(ack_clr), .vec_fetch(vec_fetch),
    .cpu_req(cpu_req), .pend_flag(pend_flag), .pin_level(pin_level));

  // reference model built from the requirements
  logic m_s1, m_s2, m_actd, m_lat;
  logic [PW-1:0] m_p1, m_p2;
  function automatic logic model_act(logic s2, logic [PW-1:0] p2, logic pen);
    return !s2 || (pen && (p2 != '0));
  endfunction
  function automatic logic model_req(logic lat, logic en, logic msk);
    return lat && en && !msk;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_p1 <= '0; m_p2 <= '0; m_actd <= 1'b0; m_lat <= 1'b0;
    end else begin
      m_s1 <= irq_n_pin; m_s2 <= m_s1; m_p1 <= port_pins; m_p2 <= m_p1;
      m_actd <= model_act(m_s2, m_p2, cfg_port_en);
      if ((model_act(m_s2, m_p2, cfg_port_en) && !m_actd) ||
          (cfg_level && model_act(m_s2, m_p2, cfg_port_en)))
        m_lat <= 1'b1;
      else if (ack_clr || vec_fetch)
        m_lat <= 1'b0;
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R7 pend_flag vs model", pend_flag, m_lat);
    check("R9 cpu_req vs model", cpu_req, model_req(m_lat, irq_en, cpu_mask));
    check("R1 pin_level vs model", pin_level, m_s2);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5150));
    #(CLK_PERIOD*3 + 2);
    // R10 reset state
    check("R10 pend in reset", pend_flag, 1'b0);
    check("R10 req in reset", cpu_req, 1'b0);
    check("R10 pin_level in reset", pin_level, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    steps(3);

    // R1 pin_level follows pin after two edges, regardless of gating
    irq_en = 1'b0; cpu_mask = 1'b1;
    irq_n_pin = 1'b0; step();
    check("R1 pin_level after one edge", pin_level, 1'b1);
    step();
    check("R1 pin_level after two edges", pin_level, 1'b0);
    step();
    vec_fetch = 1'b1; step(); vec_fetch = 1'b0;
    irq_n_pin = 1'b1; steps(4);
    irq_en = 1'b1; cpu_mask = 1'b0;

    // R2 falling edge sets latch in edge mode, 3-edge latency
    check("R2 idle before edge", pend_flag, 1'b0);
    irq_n_pin = 1'b0; steps(2);
    check("R2 not yet set", pend_flag, 1'b0);
    step();
    check("R2 set after falling edge", pend_flag, 1'b1);

    // R6 held low after fetch does not re-set in edge mode
    vec_fetch = 1'b1; step(); vec_fetch = 1'b0;
    check("R7 cleared by vec_fetch", pend_flag, 1'b0);
    steps(5);
    check("R6 held level ignored in edge mode", pend_flag, 1'b0);

    // R7 re-arm during service
    irq_n_pin = 1'b1; steps(3);
    irq_n_pin = 1'b0; steps(3);
    check("R7 first edge", pend_flag, 1'b1);
    vec_fetch = 1'b1; step(); vec_fetch = 1'b0;
    irq_n_pin = 1'b1; steps(3);
    check("R7 in service, idle", pend_flag, 1'b0);
    irq_n_pin = 1'b0; steps(3);
    check("R7 re-armed by new edge", pend_flag, 1'b1);

    // R9 mask gating, same-cycle release
    cpu_mask = 1'b1; #1;
    check("R9 masked request", cpu_req, 1'b0);
    cpu_mask = 1'b0; #1;
    check("R9 unmask shows pending", cpu_req, 1'b1);
    irq_en = 1'b0; #1;
    check("R9 enable low blocks", cpu_req, 1'b0);
    irq_en = 1'b1;

    // R5 level mode: held low keeps latch against ack
    cfg_level = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ack_clr = 1'b1; step();
      check("R5 level holds against ack", pend_flag, 1'b1);
    end
    ack_clr = 1'b0;
    irq_n_pin = 1'b1; steps(3);
    ack_clr = 1'b1; step(); ack_clr = 1'b0;
    check("R7 ack clears after release", pend_flag, 1'b0);

    // R8 set wins over same-cycle clear on a fresh edge (edge mode)
    cfg_level = 1'b0;
    irq_n_pin = 1'b0; steps(2);
    vec_fetch = 1'b1; step(); vec_fetch = 1'b0;
    check("R8 set wins over vec_fetch", pend_flag, 1'b1);
    ack_clr = 1'b1; step(); ack_clr = 1'b0;
    irq_n_pin = 1'b1; steps(3);

    // R4 port pins ignored when disabled
    cfg_port_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      port_pins = PW'(i % 2 ? 4'hF : 4'h0); step();
    end
    step(); step();
    check("R4 port pins ignored", pend_flag, 1'b0);
    cfg_level = 1'b1; port_pins = 4'hF; steps(4);
    check("R4 ignored in level mode", pend_flag, 1'b0);
    port_pins = '0; cfg_level = 1'b0; steps(3);

    // R3 rising edge on each port pin when enabled
    cfg_port_en = 1'b1; steps(3);
    for (int b = 0; b < PW; b++) begin
      port_pins = '0; port_pins[b] = 1'b1; steps(3);
      check($sformatf("R3 port bit %0d rising edge", b), pend_flag, 1'b1);
      ack_clr = 1'b1; step(); ack_clr = 1'b0;
      port_pins = '0; steps(3);
    end

    // random phases against the model
    for (int ph = 0; ph < 40; ph++) begin
      cfg_level   = 1'($urandom_range(0, 1));
      cfg_port_en = 1'($urandom_range(0, 1));
      for (int c = 0; c < 80; c++) begin
        if ($urandom_range(0, 5) == 0) irq_n_pin = ~irq_n_pin;
        if ($urandom_range(0, 5) == 0) port_pins = PW'($urandom);
        irq_en    = ($urandom_range(0, 7) != 0);
        cpu_mask  = ($urandom_range(0, 3) == 0);
        ack_clr   = ($urandom_range(0, 4) == 0);
        vec_fetch = ($urandom_range(0, 4) == 0);
        step();
      end
    end
    ack_clr = 1'b0; vec_fetch = 1'b0;
    step();
    done = 1'b1;
    finish_run();
  end
endmodule